// File: doc/BRIEF.md
# CPU Interrupt Acceptance Sequencer

This block is the processor-side controller that decides when a maskable interrupt is taken and walks the core through the entry steps. Sixteen request lines set bits in a flag register. Software owns a sixteen-bit enable register, a global mask bit and a debug mask bit. When the sequencer is idle and the global mask is clear, it takes the highest-priority line whose flag and enable bits are both set. It then runs a fixed entry sequence and finishes by loading a fetched vector into the program counter.

On entry, the sequencer first waits for a context-save handshake and pushes a snapshot of both mask bits and the enable register onto an internal stack. It then clears the taken line's flag bit, clears that line's enable bit, and raises both mask bits. Finally it asks for the vector through a request/acknowledge handshake and presents the vector as the new program counter for one cycle. A return strobe pops the snapshot and restores the masks and enables. Because entry clears only the serviced line's enable bit, a service routine can narrow the enable register and clear the global mask, which lets a chosen line nest a new entry on top of the current one.

Top module: `irq_accept_seq`

## Requirements
- R1: Priority is fixed by position. Line index 0 (flag bit 0) is the highest and index 15 the lowest. When several lines are eligible, the lowest index is taken and reported on `vec_line` as its zero-based bit index.
- R2: A high `irq_req` bit sets the matching flag bit at the next clock edge. A further request on a line whose flag is already set is absorbed and produces no extra service.
- R3: A line is accepted only when the sequencer is idle, the global mask is clear, and both its flag and enable bits are set. A pending line whose enable bit is clear is never taken.
- R4: Entry steps run in a fixed order, one clock each, except that the two handshakes wait for their acknowledges. The order is: context save (snapshot taken while flag, enable and masks are still unchanged), clear the flag bit, clear the enable bit, set the global and debug masks, vector request, program-counter load.
- R5: While the global mask is set, no line is accepted, whatever is pending.
- R6: A return strobe while idle with a non-empty stack pops the newest snapshot and restores the global mask, debug mask and enable register from it. A return strobe with an empty stack changes nothing.
- R7: An entry taken while earlier entries are unreturned pushes its snapshot on top, and `depth` counts the stacked snapshots. Returns unwind in last-in, first-out order.
- R8: An entry that arrives with all STACK_DEPTH (default 4) stack slots in use keeps the stack unchanged, still completes, and sets `stack_err`. `stack_err` then stays set until reset.
- R9: `vec_addr` is captured in the cycle `vec_ack` is high. It then appears on `pc_value` with `pc_load` high for exactly one cycle. No load happens while the acknowledge is withheld.
- R10: After reset the flag and enable registers are zero, both mask bits are set, the stack is empty, `stack_err` is clear and the sequencer is idle.
- R11: `int_en` clears the global mask and `int_dis` sets it; if both are high, the mask is set. `dbg_unmask` clears the debug mask. `ier_wr` loads the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Interrupt request lines, bit 0 highest priority |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 16 | Enable register write value |
| int_en | input | 1 | Clear the global mask |
| int_dis | input | 1 | Set the global mask |
| dbg_unmask | input | 1 | Clear the debug mask |
| iret | input | 1 | Return-from-interrupt strobe |
| ctx_save_req | output | 1 | Context save requested |
| ctx_save_ack | input | 1 | Context save complete |
| vec_req | output | 1 | Vector fetch requested |
| vec_line | output | 4 | Index of the line being serviced |
| vec_ack | input | 1 | Vector valid |
| vec_addr | input | 32 | Vector returned for the line |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 32 | Value to load into the program counter |
| ifr | output | 16 | Flag register |
| ier | output | 16 | Enable register |
| gmask | output | 1 | Global mask bit |
| dbgmask | output | 1 | Debug mask bit |
| busy | output | 1 | Entry sequence in progress |
| depth | output | 3 | Number of stacked snapshots |
| stack_err | output | 1 | Sticky stack overflow flag |

## Verification
The hardest condition to reach from the ports is stack overflow. It needs five unreturned entries at once, and each nested entry is possible only after the running routine has narrowed the enable register to one higher line and cleared the global mask again. The stimulus builds this chain from the lowest line upward. Before each new request it writes a one-hot enable and pulses the unmask strobe. It then unwinds the chain with returns and checks that the restored enable pattern is the oldest one. The other nesting case, a return whose restored state at once admits a line that has waited the whole time, comes from leaving a lower line pending under a narrowed enable register.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_CLR_FLAG,
        ST_CLR_EN,
        ST_SET_MASK,
        ST_VEC,
        ST_LOAD
    } seq_state_e;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_LINES = 16
) (
    input  logic [N_LINES-1:0]         pending,
    output logic                       any,
    output logic [$clog2(N_LINES)-1:0] idx
);
    localparam int IDX_W = $clog2(N_LINES);

    logic [N_LINES-1:0] grant;

    // Lowest index wins: scan upward and stop at the first set bit.
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (pending[i] && !any) begin
                any      = 1'b1;
                idx      = IDX_W'(i);
                grant[i] = 1'b1;
            end
        end
    end

    // R1: a single grant, only on a pending line, and no pending line below it
    always_comb begin
        a_r1_grant_onehot: assert ($onehot0(grant));
        a_r1_grant_pending: assert ((grant & ~pending) == '0);
        a_r1_no_higher_pending: assert (((grant - 1'b1) & pending & {N_LINES{any}}) == '0);
    end

endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               push_data,
    output logic [W-1:0]               top_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CNT_W-1:0]        cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    assign full  = (stk_q.cnt == CNT_W'(DEPTH));
    assign count = stk_q.cnt;

    always_comb begin
        top_data = '0;
        if (stk_q.cnt != '0) begin
            top_data = stk_q.mem[PTR_W'(stk_q.cnt - 1'b1)];
        end
    end

    always_comb begin
        stk_d = stk_q;
        if (push && !full) begin
            stk_d.mem[PTR_W'(stk_q.cnt)] = push_data;
            stk_d.cnt = stk_q.cnt + 1'b1;
        end else if (pop && stk_q.cnt != '0) begin
            stk_d.cnt = stk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    // R7: a push with room grows the stack by one
    a_r7_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (count == $past(count) + 1'b1));
    // R6: a pop from a non-empty stack shrinks it by one
    a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count != '0) |=> (count == $past(count) - 1'b1));
    // R8: a push into a full stack leaves it full
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> full);

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_seq_pkg::*;
#(
    parameter int N_LINES     = 16,
    parameter int STACK_DEPTH = 4,
    parameter int PC_W        = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_LINES-1:0]             irq_req,
    input  logic                           ier_wr,
    input  logic [N_LINES-1:0]             ier_wdata,
    input  logic                           int_en,
    input  logic                           int_dis,
    input  logic                           dbg_unmask,
    input  logic                           iret,
    output logic                           ctx_save_req,
    input  logic                           ctx_save_ack,
    output logic                           vec_req,
    output logic [$clog2(N_LINES)-1:0]     vec_line,
    input  logic                           vec_ack,
    input  logic [PC_W-1:0]                vec_addr,
    output logic                           pc_load,
    output logic [PC_W-1:0]                pc_value,
    output logic [N_LINES-1:0]             ifr,
    output logic [N_LINES-1:0]             ier,
    output logic                           gmask,
    output logic                           dbgmask,
    output logic                           busy,
    output logic [$clog2(STACK_DEPTH+1)-1:0] depth,
    output logic                           stack_err
);
    localparam int IDX_W = $clog2(N_LINES);
    localparam int CTX_W = N_LINES + 2;
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [IDX_W-1:0]   sel;
        logic [N_LINES-1:0] ifr;
        logic [N_LINES-1:0] ier;
        logic               gm;
        logic               dm;
        logic               err;
        logic [PC_W-1:0]    pc;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic               stk_push, stk_pop, stk_full;
    logic [CTX_W-1:0]   stk_top;
    logic [CNT_W-1:0]   stk_cnt;
    logic [N_LINES-1:0] flag_clr;

    irq_prio_pick #(.N_LINES(N_LINES)) u_pick (
        .pending (r_q.ifr & r_q.ier),
        .any     (pick_any),
        .idx     (pick_idx)
    );

    irq_ctx_stack #(.W(CTX_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data ({r_q.gm, r_q.dm, r_q.ier}),
        .top_data  (stk_top),
        .count     (stk_cnt),
        .full      (stk_full)
    );

    always_comb begin
        r_d      = r_q;
        stk_push = 1'b0;
        stk_pop  = iret && (r_q.st == ST_IDLE) && (stk_cnt != '0);

        flag_clr = '0;
        if (r_q.st == ST_CLR_FLAG) begin
            flag_clr[r_q.sel] = 1'b1;
        end
        r_d.ifr = (r_q.ifr & ~flag_clr) | irq_req;

        if (stk_pop) begin
            r_d.gm  = stk_top[CTX_W-1];
            r_d.dm  = stk_top[CTX_W-2];
            r_d.ier = stk_top[N_LINES-1:0];
        end else begin
            if (ier_wr)     r_d.ier = ier_wdata;
            if (int_en)     r_d.gm  = 1'b0;
            if (int_dis)    r_d.gm  = 1'b1;
            if (dbg_unmask) r_d.dm  = 1'b0;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (!iret && !r_q.gm && pick_any) begin
                    r_d.st  = ST_SAVE;
                    r_d.sel = pick_idx;
                end
            end
            ST_SAVE: begin
                if (ctx_save_ack) begin
                    stk_push = 1'b1;
                    if (stk_full) r_d.err = 1'b1;
                    r_d.st = ST_CLR_FLAG;
                end
            end
            ST_CLR_FLAG: r_d.st = ST_CLR_EN;
            ST_CLR_EN: begin
                r_d.ier[r_q.sel] = 1'b0;
                r_d.st = ST_SET_MASK;
            end
            ST_SET_MASK: begin
                r_d.gm = 1'b1;
                r_d.dm = 1'b1;
                r_d.st = ST_VEC;
            end
            ST_VEC: begin
                if (vec_ack) begin
                    r_d.pc = vec_addr;
                    r_d.st = ST_LOAD;
                end
            end
            ST_LOAD: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.sel <= '0;
            r_q.ifr <= '0;
            r_q.ier <= '0;
            r_q.gm  <= 1'b1;
            r_q.dm  <= 1'b1;
            r_q.err <= 1'b0;
            r_q.pc  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctx_save_req = (r_q.st == ST_SAVE);
    assign vec_req      = (r_q.st == ST_VEC);
    assign vec_line     = r_q.sel;
    assign pc_load      = (r_q.st == ST_LOAD);
    assign pc_value     = r_q.pc;
    assign ifr          = r_q.ifr;
    assign ier          = r_q.ier;
    assign gmask        = r_q.gm;
    assign dbgmask      = r_q.dm;
    assign busy         = (r_q.st != ST_IDLE);
    assign depth        = stk_cnt;
    assign stack_err    = r_q.err;

    // R4: flag bit of the taken line is gone after its clear step
    a_r4_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CLR_FLAG && !irq_req[r_q.sel]) |=> !ifr[vec_line]);
    // R4: enable bit of the taken line is gone after its clear step
    a_r4_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CLR_EN) |=> !ier[vec_line]);
    // R4: both masks are up when the vector is requested
    a_r4_masks_before_vector: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (gmask && dbgmask));
    // R5: a set global mask blocks acceptance
    a_r5_masked_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && gmask) |=> !ctx_save_req);
    // R3: nothing eligible means nothing starts
    a_r3_no_eligible_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ((ifr & ier) == '0)) |=> !ctx_save_req);
    // R8: the overflow flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);
    // R9: load strobe lasts one cycle and follows an acknowledged vector
    a_r9_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);
    a_r9_load_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_ack) |=> (pc_load && pc_value == $past(vec_addr)));

endmodule

// File: tb/tb_irq_accept_seq.sv
module tb_irq_accept_seq;
    localparam int N    = 16;
    localparam int SD   = 4;
    localparam int PCW  = 32;
    localparam int IW   = 4;
    localparam int CW   = 3;
    localparam logic [31:0] BASE = 32'h0000_8000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   irq_req = '0;
    logic           ier_wr = 1'b0;
    logic [N-1:0]   ier_wdata = '0;
    logic           int_en = 1'b0, int_dis = 1'b0, dbg_unmask = 1'b0, iret = 1'b0;
    logic           ctx_save_req, ctx_save_ack = 1'b0;
    logic           vec_req, vec_ack = 1'b0;
    logic [IW-1:0]  vec_line;
    logic [PCW-1:0] vec_addr = '0;
    logic           pc_load;
    logic [PCW-1:0] pc_value;
    logic [N-1:0]   ifr, ier;
    logic           gmask, dbgmask, busy, stack_err;
    logic [CW-1:0]  depth;

    int checks = 0, fails = 0, loads = 0;
    int exp_q[$];
    int vec_delay = 0, vwait = 0;

    always #4 clk = ~clk;

    irq_accept_seq #(.N_LINES(N), .STACK_DEPTH(SD), .PC_W(PCW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .int_en(int_en), .int_dis(int_dis), .dbg_unmask(dbg_unmask), .iret(iret),
        .ctx_save_req(ctx_save_req), .ctx_save_ack(ctx_save_ack),
        .vec_req(vec_req), .vec_line(vec_line), .vec_ack(vec_ack), .vec_addr(vec_addr),
        .pc_load(pc_load), .pc_value(pc_value), .ifr(ifr), .ier(ier),
        .gmask(gmask), .dbgmask(dbgmask), .busy(busy), .depth(depth), .stack_err(stack_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Responder: context save acknowledged at once, vector after vec_delay cycles
    always @(negedge clk) begin
        ctx_save_ack <= ctx_save_req;
        if (vec_req) begin
            if (vwait >= vec_delay) begin
                vec_ack  <= 1'b1;
                vec_addr <= BASE + 32'(vec_line) * 4;
            end else begin
                vec_ack <= 1'b0;
                vwait   <= vwait + 1;
            end
        end else begin
            vec_ack <= 1'b0;
            vwait   <= 0;
        end
    end

    // Monitor: every program-counter load is compared with the scoreboard
    always @(negedge clk) begin
        if (rst_n && pc_load) begin
            loads++;
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R3 unexpected load actual=%h expected=none", pc_value);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R9 pc_value", pc_value, BASE + 32'(e) * 4);
                check("R1 vec_line", 32'(vec_line), 32'(e));
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask
    task automatic pulse_req(input logic [N-1:0] m);
        irq_req = m; step(); irq_req = '0;
    endtask
    task automatic set_ier(input logic [N-1:0] v);
        ier_wr = 1'b1; ier_wdata = v; step(); ier_wr = 1'b0;
    endtask
    task automatic unmask();
        int_en = 1'b1; step(); int_en = 1'b0;
    endtask
    task automatic mask();
        int_dis = 1'b1; step(); int_dis = 1'b0;
    endtask
    task automatic do_ret();
        iret = 1'b1; step(); iret = 1'b0;
    endtask
    task automatic wait_service(string tag);
        bit seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            step();
            if (pc_load) seen = 1'b1;
        end
        step();
        check(tag, 32'(seen), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R10 reset state
        check("R10 ifr", 32'(ifr), 0);
        check("R10 ier", 32'(ier), 0);
        check("R10 masks", {30'd0, gmask, dbgmask}, 32'd3);
        check("R10 depth/err/busy", {27'd0, depth, stack_err, busy}, 0);

        // R2 absorption and R5 masking
        pulse_req(16'h0040); step(); pulse_req(16'h0040);
        check("R2 flag set", 32'(ifr), 32'h0040);
        set_ier(16'hFFFF);
        repeat (4) step();
        check("R5 masked busy", 32'(busy), 0);
        check("R5 masked loads", 32'(loads), 0);
        exp_q.push_back(6);
        unmask();
        wait_service("R3 service line 6");
        check("R2 flag cleared once", 32'(ifr), 0);
        check("R4 enable cleared", 32'(ier), 32'hFFBF);
        check("R4 masks set", {30'd0, gmask, dbgmask}, 32'd3);
        check("R7 depth one", 32'(depth), 1);
        do_ret();
        check("R6 restore gmask", 32'(gmask), 0);
        check("R6 restore ier", 32'(ier), 32'hFFFF);
        check("R6 depth zero", 32'(depth), 0);
        repeat (5) step();
        check("R2 single service", 32'(loads), 1);

        // R1 priority and R4 step order
        exp_q.push_back(2);
        pulse_req(16'h0014);
        for (int i = 0; i < 20 && !ctx_save_req; i++) step();
        check("R4 snapshot point flag", 32'(ifr[2]), 1);
        check("R4 snapshot point enable", 32'(ier[2]), 1);
        check("R4 snapshot point mask", 32'(gmask), 0);
        step();
        step();
        check("R4 flag cleared first", {30'd0, ifr[2], ier[2]}, 32'd1);
        step();
        check("R4 enable cleared second", {30'd0, ier[2], gmask}, 32'd0);
        step();
        check("R4 masks before vector", {29'd0, gmask, dbgmask, vec_req}, 32'd7);
        wait_service("R1 service line 2");
        check("R1 lower line still pending", 32'(ifr), 32'h0010);

        // R5 pending line held off by the mask
        repeat (6) step();
        check("R5 no accept", {30'd0, busy, 1'b0}, 0);
        check("R5 loads", 32'(loads), 2);

        // R7 nesting through a narrowed enable register
        set_ier(16'h0001);
        unmask();
        repeat (4) step();
        check("R3 disabled line not taken", 32'(busy), 0);
        exp_q.push_back(0);
        pulse_req(16'h0001);
        wait_service("R7 nested line 0");
        check("R7 depth two", 32'(depth), 2);
        check("R7 nested enable", 32'(ier), 0);

        // R6 unwind; second return admits the waiting line
        do_ret();
        check("R6 inner restore", {15'd0, gmask, ier}, 32'h0000_0001);
        check("R6 inner depth", 32'(depth), 1);
        repeat (4) step();
        check("R3 still disabled", 32'(loads), 3);
        mask();
        exp_q.push_back(4);
        do_ret();
        wait_service("R6 restored admits line 4");
        check("R6 after restore entry", 32'(ier), 32'hFFEF);
        check("R6 after restore depth", 32'(depth), 1);
        do_ret();
        check("R6 final restore", {15'd0, gmask, ier}, 32'h0000_FFFF);
        set_ier(16'h1234);
        do_ret();
        check("R6 empty return ignored", {12'd0, depth, gmask, ier}, 32'h0000_1234);
        set_ier(16'hFFFF);

        // R9 vector handshake wait
        vec_delay = 3;
        exp_q.push_back(9);
        pulse_req(16'h0200);
        for (int i = 0; i < 20 && !vec_req; i++) step();
        step();
        step();
        check("R9 waits for ack", {30'd0, vec_req, pc_load}, 32'd2);
        wait_service("R9 delayed vector");
        do_ret();
        vec_delay = 0;

        // R8 overflow through five nested entries
        exp_q.push_back(15);
        pulse_req(16'h8000);
        wait_service("R8 entry line 15");
        for (int k = 14; k >= 11; k--) begin
            if (k == 11) check("R8 no error before", 32'(stack_err), 0);
            set_ier(16'(1 << k));
            unmask();
            exp_q.push_back(k);
            pulse_req(16'(1 << k));
            wait_service("R8 nested entry");
        end
        check("R8 error set", 32'(stack_err), 1);
        check("R8 depth capped", 32'(depth), SD);
        for (int k = 0; k < SD; k++) do_ret();
        check("R8 unwound depth", 32'(depth), 0);
        check("R8 error sticky", 32'(stack_err), 1);
        check("R7 oldest context restored", {15'd0, gmask, ier}, 32'h0000_FFFF);

        // R11 software mask controls
        int_en = 1'b1; int_dis = 1'b1; step(); int_en = 1'b0; int_dis = 1'b0;
        check("R11 set wins", 32'(gmask), 1);
        dbg_unmask = 1'b1; step(); dbg_unmask = 1'b0;
        check("R11 debug unmask", 32'(dbgmask), 0);
        check("R9 scoreboard drained", 32'(exp_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule